// File: doc/BRIEF.md
# Byte-Oriented Instruction Execute Unit

This block carries out the byte-wide register-file instructions of a 14-bit instruction word. An instruction is offered together with the current working register W and the operand already read from the addressed file register. The unit computes the result and picks its destination: either W or the file register. It raises write enables for the zero, carry and digit-carry flags, each with its new value. For the increment-and-skip and decrement-and-skip forms, it tells the sequencer to skip the next instruction. The register file, fetch, bit-oriented and literal/control instructions belong to neighbouring blocks.

Operation is built around a three-state sequencer: ST_IDLE, ST_EXEC and ST_SKIP.
- ST_IDLE: nothing is in flight. An accepted issue moves the sequencer to ST_EXEC (transition IDLE_TO_EXEC).
- ST_EXEC: the registered results are presented for one cycle with `done` high. From here the sequencer moves:
  - to ST_SKIP when the instruction skips (EXEC_TO_SKIP),
  - to ST_EXEC again when a new instruction is accepted in the same cycle (EXEC_TO_EXEC),
  - otherwise back to ST_IDLE (EXEC_TO_IDLE).
- ST_SKIP: this is the added second cycle of a skipping instruction. It leaves to ST_EXEC when a new issue is accepted (SKIP_TO_EXEC), otherwise to ST_IDLE (SKIP_TO_IDLE).

Instruction field layout:
- bits 13:8 hold the opcode,
- bit 7 holds the destination select,
- bits 6:0 hold the file address.

Top module: `xu_exec`

## Requirements
- R1: An issue is accepted on a rising edge where `issue` and `ready` are both high. Exactly one cycle later, `done` is high for one cycle. At that point `f_addr` equals instruction bits 6:0 and `cycles` is 1 or 2.
- R2: Opcode 000111 (add) gives result = (W + f) mod 256. C is the carry out of bit 7 and DC is the carry out of bit 3. Z is set when the result is 0. `z_we`, `c_we` and `dc_we` are all high.
- R3: Opcodes 000101 (AND), 000100 (OR), 001001 (complement of f) and 001000 (move f) give W&f, W|f, ~f and f. Only `z_we` is high; `c_we` and `dc_we` stay low.
- R4: Opcodes 000011 (f-1) and 001010 (f+1) wrap modulo 256. Only `z_we` is high.
- R5: Opcode 000001 gives result 0 with Z = 1 and `z_we` high. When bit 7 is 1 the result goes to f; when bit 7 is 0 it goes to W, and bits 6:0 do not affect anything except `f_addr`.
- R6: For every legal opcode, bit 7 = 0 raises `wr_w` only and bit 7 = 1 raises `wr_f` only. Both stay low whenever `done` is low.
- R7: Opcodes 001011 (f-1 and skip) and 001111 (f+1 and skip) write their result per R6 and raise no flag write enable. `skip` is high exactly when the result is 0.
- R8: `cycles` reads 2 for a skipping instruction and 1 for every other instruction.
- R9: For a skipping instruction, `ready` is low in its `done` cycle. An issue offered in that cycle is not taken. The following cycle has `done` low, and a new issue can be accepted on its closing edge.
- R10: Any other opcode raises `illegal`. It gives no register write, no flag write, no skip, a result of 0 and `cycles` = 1.
- R11: A flag value output (`z`, `c`, `dc`) is 0 whenever its write enable is low. After reset, `ready` is 1 and `done` and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Instruction offered this cycle |
| instr | input | 14 | Instruction word |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Operand read from the addressed file register |
| ready | output | 1 | An issue can be accepted this cycle |
| done | output | 1 | Results valid this cycle |
| result | output | 8 | Computed value |
| f_addr | output | 7 | File address for the write-back |
| wr_w | output | 1 | Write result to W |
| wr_f | output | 1 | Write result to the file register |
| z_we | output | 1 | Zero flag write enable |
| z | output | 1 | New zero flag |
| c_we | output | 1 | Carry flag write enable |
| c | output | 1 | New carry flag |
| dc_we | output | 1 | Digit-carry flag write enable |
| dc | output | 1 | New digit-carry flag |
| skip | output | 1 | Skip the next instruction |
| cycles | output | 2 | Cycle count of the instruction |
| illegal | output | 1 | Opcode outside the implemented set |

## Verification
The hardest situation to create from the ports is an issue that arrives in the `done` cycle of a skipping instruction. Random operands almost never make an increment or decrement land on zero, so the stimulus forces f to 0xFF for the increment-skip form and to 0x01 for the decrement-skip form. A directed sequence then holds a second issue high across the stalled cycle. The bench checks that this issue is taken only after the ST_SKIP cycle and that its own result follows one cycle later. Carry out of bit 3 and bit 7 is also seeded directly with operands such as 0x0F + 0x01 and 0xFF + 0x01.

// File: rtl/xu_pkg.sv
package xu_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_CLR   = 6'b000001;
    localparam logic [OPC_W-1:0] OPC_DEC   = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_IOR   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_AND   = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_ADD   = 6'b000111;
    localparam logic [OPC_W-1:0] OPC_MOV   = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_COM   = 6'b001001;
    localparam logic [OPC_W-1:0] OPC_INC   = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_DECSZ = 6'b001011;
    localparam logic [OPC_W-1:0] OPC_INCSZ = 6'b001111;

    typedef enum logic [3:0] {
        K_ADD, K_AND, K_IOR, K_COM, K_DEC, K_INC,
        K_MOV, K_DECSZ, K_INCSZ, K_CLR, K_BAD
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_EXEC, ST_SKIP
    } xu_state_e;

endpackage

// File: rtl/xu_decode.sv
module xu_decode
    import xu_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [OPC_W+ADDR_W:0] instr,
    output op_kind_e              kind,
    output logic                  to_file,
    output logic [ADDR_W-1:0]     addr
);
    localparam int D_BIT = ADDR_W;

    logic [OPC_W-1:0] opc;
    assign opc  = instr[OPC_W+ADDR_W:ADDR_W+1];
    assign addr = instr[ADDR_W-1:0];

    always_comb begin
        unique case (opc)
            OPC_ADD:   kind = K_ADD;
            OPC_AND:   kind = K_AND;
            OPC_IOR:   kind = K_IOR;
            OPC_COM:   kind = K_COM;
            OPC_DEC:   kind = K_DEC;
            OPC_INC:   kind = K_INC;
            OPC_MOV:   kind = K_MOV;
            OPC_DECSZ: kind = K_DECSZ;
            OPC_INCSZ: kind = K_INCSZ;
            OPC_CLR:   kind = K_CLR;
            default:   kind = K_BAD;
        endcase
    end

    // The clear opcode uses the same bit for f/W choice as the d field.
    assign to_file = instr[D_BIT];

endmodule

// File: rtl/xu_alu.sv
module xu_alu
    import xu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DC_BIT = 3
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] w,
    input  logic [DATA_W-1:0] f,
    output logic [DATA_W-1:0] res,
    output logic              carry,
    output logic              dcarry,
    output logic              is_zero
);
    localparam int LOW_W = DC_BIT + 1;

    logic [DATA_W:0] sum;
    logic [LOW_W:0]  low_sum;

    assign sum     = {1'b0, w} + {1'b0, f};
    assign low_sum = {1'b0, w[DC_BIT:0]} + {1'b0, f[DC_BIT:0]};
    assign carry   = sum[DATA_W];
    assign dcarry  = low_sum[LOW_W];

    always_comb begin
        unique case (kind)
            K_ADD:            res = sum[DATA_W-1:0];
            K_AND:            res = w & f;
            K_IOR:            res = w | f;
            K_COM:            res = ~f;
            K_DEC, K_DECSZ:   res = f - 1'b1;
            K_INC, K_INCSZ:   res = f + 1'b1;
            K_MOV:            res = f;
            K_CLR, K_BAD:     res = '0;
            default:          res = '0;
        endcase
    end

    assign is_zero = (res == '0);

endmodule

// File: rtl/xu_exec.sv
module xu_exec
    import xu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7,
    parameter int DC_BIT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [OPC_W+ADDR_W:0] instr,
    input  logic [DATA_W-1:0]     w_in,
    input  logic [DATA_W-1:0]     f_in,
    output logic                  ready,
    output logic                  done,
    output logic [DATA_W-1:0]     result,
    output logic [ADDR_W-1:0]     f_addr,
    output logic                  wr_w,
    output logic                  wr_f,
    output logic                  z_we,
    output logic                  z,
    output logic                  c_we,
    output logic                  c,
    output logic                  dc_we,
    output logic                  dc,
    output logic                  skip,
    output logic [1:0]            cycles,
    output logic                  illegal
);
    op_kind_e          kind;
    logic              to_file;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] res;
    logic              carry, dcarry, is_zero;

    xu_decode #(.ADDR_W(ADDR_W)) u_dec (
        .instr   (instr),
        .kind    (kind),
        .to_file (to_file),
        .addr    (addr)
    );

    xu_alu #(.DATA_W(DATA_W), .DC_BIT(DC_BIT)) u_alu (
        .kind    (kind),
        .w       (w_in),
        .f       (f_in),
        .res     (res),
        .carry   (carry),
        .dcarry  (dcarry),
        .is_zero (is_zero)
    );

    // Next-cycle values derived from the decoded kind
    logic bad_n, zwe_n, cwe_n, skip_n;
    assign bad_n  = (kind == K_BAD);
    assign zwe_n  = !bad_n && (kind != K_DECSZ) && (kind != K_INCSZ);
    assign cwe_n  = (kind == K_ADD);
    assign skip_n = ((kind == K_DECSZ) || (kind == K_INCSZ)) && is_zero;

    xu_state_e state_q, state_n;
    logic      accept;

    logic [DATA_W-1:0] res_q;
    logic [ADDR_W-1:0] addr_q;
    logic wrw_q, wrf_q, zwe_q, z_q, cwe_q, c_q, dc_q, skip_q, bad_q;

    assign ready  = (state_q != ST_EXEC) || !skip_q;
    assign accept = issue && ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: state_n = accept ? ST_EXEC : ST_IDLE;
            ST_EXEC: begin
                if (skip_q)      state_n = ST_SKIP;
                else if (accept) state_n = ST_EXEC;
                else             state_n = ST_IDLE;
            end
            ST_SKIP: state_n = accept ? ST_EXEC : ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Capture of results on an accepted issue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            addr_q <= '0;
            wrw_q  <= 1'b0;
            wrf_q  <= 1'b0;
            zwe_q  <= 1'b0;
            z_q    <= 1'b0;
            cwe_q  <= 1'b0;
            c_q    <= 1'b0;
            dc_q   <= 1'b0;
            skip_q <= 1'b0;
            bad_q  <= 1'b0;
        end else if (accept) begin
            res_q  <= res;
            addr_q <= addr;
            wrw_q  <= !bad_n && !to_file;
            wrf_q  <= !bad_n && to_file;
            zwe_q  <= zwe_n;
            z_q    <= zwe_n && is_zero;
            cwe_q  <= cwe_n;
            c_q    <= cwe_n && carry;
            dc_q   <= cwe_n && dcarry;
            skip_q <= skip_n;
            bad_q  <= bad_n;
        end
    end

    // Outputs, qualified by the execute state
    always_comb begin
        done    = 1'b0;
        result  = '0;
        f_addr  = '0;
        wr_w    = 1'b0;
        wr_f    = 1'b0;
        z_we    = 1'b0;
        z       = 1'b0;
        c_we    = 1'b0;
        c       = 1'b0;
        dc_we   = 1'b0;
        dc      = 1'b0;
        skip    = 1'b0;
        cycles  = 2'd0;
        illegal = 1'b0;
        unique case (state_q)
            ST_EXEC: begin
                done    = 1'b1;
                result  = res_q;
                f_addr  = addr_q;
                wr_w    = wrw_q;
                wr_f    = wrf_q;
                z_we    = zwe_q;
                z       = z_q;
                c_we    = cwe_q;
                c       = c_q;
                dc_we   = cwe_q;
                dc      = dc_q;
                skip    = skip_q;
                cycles  = skip_q ? 2'd2 : 2'd1;
                illegal = bad_q;
            end
            ST_IDLE, ST_SKIP: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/xu_exec_chk.sv
module xu_exec_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic              ready,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              wr_w,
    input logic              wr_f,
    input logic              z_we,
    input logic              z,
    input logic              c_we,
    input logic              c,
    input logic              dc_we,
    input logic              dc,
    input logic              skip,
    input logic [1:0]        cycles,
    input logic              illegal
);
    assert_accept_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ready) |=> done);

    assert_add_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |-> (dc_we && z_we));

    assert_zero_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && z_we) |-> (z == (result == '0)));

    assert_one_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_w && wr_f));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!wr_w && !wr_f && !z_we && !c_we && !skip));

    assert_skip_no_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (!z_we && !c_we && !dc_we && result == '0));

    assert_cycle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles == (skip ? 2'd2 : 2'd1)));

    assert_skip_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && skip) |-> !ready);

    assert_skip_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && skip) |=> !done);

    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_w && !wr_f && !z_we && !skip));

    assert_flag_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((!z_we -> !z) && (!c_we -> !c) && (!dc_we -> !dc)));
endmodule

bind xu_exec xu_exec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .ready   (ready),
    .done    (done),
    .result  (result),
    .wr_w    (wr_w),
    .wr_f    (wr_f),
    .z_we    (z_we),
    .z       (z),
    .c_we    (c_we),
    .c       (c),
    .dc_we   (dc_we),
    .dc      (dc),
    .skip    (skip),
    .cycles  (cycles),
    .illegal (illegal)
);

// File: tb/xu_exec_test.sv
`timescale 1ns/1ps
module xu_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [13:0] instr = '0;
    logic [7:0]  w_in = '0;
    logic [7:0]  f_in = '0;
    logic        ready, done, wr_w, wr_f, z_we, z, c_we, c, dc_we, dc, skip, illegal;
    logic [7:0]  result;
    logic [6:0]  f_addr;
    logic [1:0]  cycles;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    xu_exec uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .w_in(w_in), .f_in(f_in), .ready(ready), .done(done),
        .result(result), .f_addr(f_addr), .wr_w(wr_w), .wr_f(wr_f),
        .z_we(z_we), .z(z), .c_we(c_we), .c(c), .dc_we(dc_we), .dc(dc),
        .skip(skip), .cycles(cycles), .illegal(illegal)
    );

    // Packed outputs: result, cycles, skip, dc, dc_we, c, c_we, z, z_we, wr_f, wr_w, illegal
    function automatic logic [19:0] model(input logic [13:0] ins,
                                          input logic [7:0] w, input logic [7:0] f);
        logic [5:0] op;
        logic [8:0] s;
        logic [4:0] lo;
        logic [7:0] r;
        logic bad_op, zwe, cwe, sk, d;
        op = ins[13:8];
        d  = ins[7];
        s  = {1'b0, w} + {1'b0, f};
        lo = {1'b0, w[3:0]} + {1'b0, f[3:0]};
        bad_op = 1'b0; zwe = 1'b1; cwe = 1'b0; sk = 1'b0;
        case (op)
            6'b000111: begin r = s[7:0]; cwe = 1'b1; end
            6'b000101: r = w & f;
            6'b000100: r = w | f;
            6'b001001: r = ~f;
            6'b000011: r = f - 8'd1;
            6'b001010: r = f + 8'd1;
            6'b001000: r = f;
            6'b000001: r = 8'd0;
            6'b001011: begin r = f - 8'd1; zwe = 1'b0; sk = (r == 0); end
            6'b001111: begin r = f + 8'd1; zwe = 1'b0; sk = (r == 0); end
            default:   begin r = 8'd0; zwe = 1'b0; bad_op = 1'b1; end
        endcase
        return {r, (sk ? 2'd2 : 2'd1), sk, cwe & lo[4], cwe, cwe & s[8], cwe,
                zwe & (r == 0), zwe, !bad_op & d, !bad_op & !d, bad_op};
    endfunction

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            6'b000111: return "R2";
            6'b000101, 6'b000100, 6'b001001, 6'b001000: return "R3";
            6'b000011, 6'b001010: return "R4";
            6'b000001: return "R5";
            6'b001011, 6'b001111: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] observed();
        return {result, cycles, skip, dc, dc_we, c, c_we, z, z_we, wr_f, wr_w, illegal};
    endfunction

    // Drive at a negedge; results are sampled at the following negedge.
    task automatic run_op(input logic [13:0] ins, input logic [7:0] w, input logic [7:0] f);
        logic [19:0] exp;
        exp = model(ins, w, f);
        @(negedge clk);
        instr = ins; w_in = w; f_in = f; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        check(done === 1'b1 && f_addr === ins[6:0], "R1",
              {24'd0, done, f_addr}, {24'd0, 1'b1, ins[6:0]});
        check(observed() === exp, tag_of(ins[13:8]), {12'd0, observed()}, {12'd0, exp});
        check((wr_w && wr_f) === 1'b0, "R6", {31'd0, wr_w & wr_f}, 32'd0);
        if (exp[10]) begin
            @(negedge clk);
            check(done === 1'b0, "R9", {31'd0, done}, 32'd0);
            check(cycles === 2'd2 || cycles === 2'd0, "R8", {30'd0, cycles}, 32'd0);
        end
    endtask

    localparam logic [5:0] OPS [10] = '{6'b000111, 6'b000101, 6'b000100, 6'b001001,
        6'b000011, 6'b001010, 6'b001000, 6'b000001, 6'b001011, 6'b001111};

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R11: reset state
        check(ready === 1'b1 && done === 1'b0 && wr_w === 1'b0 && wr_f === 1'b0 &&
              z_we === 1'b0 && c_we === 1'b0, "R11",
              {26'd0, ready, done, wr_w, wr_f, z_we, c_we}, {26'd0, 6'b100000});
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run_op({6'b000111, 1'b0, 7'h11}, 8'h0F, 8'h01); // R2 digit carry
        run_op({6'b000111, 1'b1, 7'h22}, 8'hFF, 8'h01); // R2 carry and zero
        run_op({6'b000111, 1'b0, 7'h05}, 8'h80, 8'h80); // R2 carry without DC
        run_op({6'b001111, 1'b1, 7'h30}, 8'h00, 8'hFF); // R7 increment skip
        run_op({6'b001011, 1'b0, 7'h31}, 8'h00, 8'h01); // R7 decrement skip
        run_op({6'b001011, 1'b1, 7'h32}, 8'h00, 8'h00); // R7 wrap, no skip
        run_op({6'b000011, 1'b0, 7'h12}, 8'h00, 8'h00); // R4 wrap to FF
        run_op({6'b001010, 1'b1, 7'h13}, 8'h00, 8'hFF); // R4 wrap to 00, Z set
        run_op({6'b000001, 1'b0, 7'h7F}, 8'hAA, 8'h55); // R5 clear W, junk low bits
        run_op({6'b000001, 1'b1, 7'h40}, 8'hAA, 8'h55); // R5 clear f
        run_op({6'b111111, 1'b1, 7'h01}, 8'h12, 8'h34); // R10 illegal
        run_op({6'b000000, 1'b0, 7'h01}, 8'h12, 8'h34); // R10 illegal
        run_op({6'b001000, 1'b0, 7'h02}, 8'h00, 8'h00); // R3 move zero

        // R9: issue held across the stalled cycle of a skipping instruction
        @(negedge clk);
        instr = {6'b001111, 1'b0, 7'h50}; w_in = 8'h00; f_in = 8'hFF; issue = 1'b1;
        @(negedge clk);
        check(done === 1'b1 && skip === 1'b1 && ready === 1'b0, "R9",
              {29'd0, done, skip, ready}, {29'd0, 3'b110});
        instr = {6'b000111, 1'b0, 7'h51}; w_in = 8'h03; f_in = 8'h04;
        @(negedge clk);
        check(done === 1'b0, "R9", {31'd0, done}, 32'd0);
        @(negedge clk);
        issue = 1'b0;
        check(done === 1'b1 && result === 8'h07 && f_addr === 7'h51, "R9",
              {23'd0, done, result}, {23'd0, 1'b1, 8'h07});
        // R1: back-to-back acceptance of non-skipping instructions
        @(negedge clk);
        instr = {6'b001010, 1'b1, 7'h60}; f_in = 8'h10; issue = 1'b1;
        @(negedge clk);
        instr = {6'b001010, 1'b1, 7'h61}; f_in = 8'h20;
        check(done === 1'b1 && result === 8'h11 && ready === 1'b1, "R1",
              {23'd0, done, result}, {23'd0, 1'b1, 8'h11});
        @(negedge clk);
        issue = 1'b0;
        check(done === 1'b1 && result === 8'h21 && f_addr === 7'h61, "R1",
              {23'd0, done, result}, {23'd0, 1'b1, 8'h21});

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [5:0] op;
            logic [7:0] fv;
            int pick;
            pick = $urandom_range(0, 11);
            if (pick < 10) op = OPS[pick];
            else           op = 6'($urandom());
            fv = 8'($urandom());
            if ((op == 6'b001111) && ($urandom_range(0, 2) == 0)) fv = 8'hFF;
            if ((op == 6'b001011) && ($urandom_range(0, 2) == 0)) fv = 8'h01;
            run_op({op, 1'($urandom()), 7'($urandom())}, 8'($urandom()), fv);
        end

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule